// File: doc/BRIEF.md
# Masked Interrupt Register Block

This block gathers ten interrupt sources into one level interrupt line behind a 32-bit register port. Each source owns a sticky pending bit. A pending bit is set by a rising edge on its hardware event input, or by software through a trigger register. Software clears a pending bit by writing one to it. A mask bit per source decides whether a pending bit can drive the interrupt line. Software never writes the mask directly. It clears mask bits through an enable register and sets them through a disable register.

The block also holds a small control register and a read-only status word. Writing the scan-request bit of the control register makes the status word report a finished, passing scan in the next cycle. The status word shows configuration-complete from reset onward. The register port has no handshake. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `ictl_top`

## Requirements
- R1: After reset, pending = 0x000, mask = 0x3FF (all sources masked), control = 0, status = 0x1 (bit 0 = configuration complete), and irq_o is low.
- R2: A write to the mask register (offset 0x04) has no effect on it. The mask reads back there as bits [9:0].
- R3: Writing the enable register (0x08) clears every mask bit whose data bit is 1. Writing the disable register (0x0C) sets every such mask bit. Both registers read as zero.
- R4: The pending register (0x00) holds bits [9:0]. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Bits [31:10] read as zero.
- R5: Writing the trigger register (0x10) sets every pending bit whose data bit is 1. The register reads as zero.
- R6: irq_o is high exactly when some pending bit is set while its mask bit is clear. It reflects the register state updated by the same clock edge as any write.
- R7: A 0-to-1 transition on evt_i[k] sets pending bit k at the next edge. An input held high does not set the bit again after it has been cleared.
- R8: When an event edge on source k and a write-1-to-clear of bit k fall on the same edge, bit k ends up set.
- R9: The control register (0x18) stores bits [14:0], and bits [31:15] read as zero. Writing 1 to control bit 0 sets status bit 1 (scan done) and status bit 2 (scan passed). Status bits stay set once set. Writes to the status register (0x20) are ignored.
- R10: Every other address reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_i | input | 10 | Hardware event levels, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
Directed sequences cover the following cases:
- Triggering sources while they are masked, then unmasking one of them, separates the pending path from the mask gate on irq_o.
- Holding an event input high across a write-1-to-clear separates edge detection from level sensing.
- Placing a fresh event edge on the same edge as a clear of that bit exposes the priority between set and clear.

A fixed-seed random phase then mixes writes to every mapped and unmapped offset with toggling event inputs. After every edge it compares each readable register and irq_o with a bench model. This catches wrong decodes, writes that leak to other registers, and reserved bits that read nonzero.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  // Register byte offsets
  localparam logic [7:0] OFF_PEND = 8'h00;
  localparam logic [7:0] OFF_MASK = 8'h04;
  localparam logic [7:0] OFF_UNMS = 8'h08;
  localparam logic [7:0] OFF_MSET = 8'h0C;
  localparam logic [7:0] OFF_TRIG = 8'h10;
  localparam logic [7:0] OFF_CTRL = 8'h18;
  localparam logic [7:0] OFF_STAT = 8'h20;

  // Status bit positions
  localparam int ST_CMPL = 0;
  localparam int ST_DONE = 1;
  localparam int ST_PASS = 2;
  localparam int ST_W    = 3;

  // Control bit that requests a scan
  localparam int CT_SCAN = 0;

  // Any pending source that is not masked
  function automatic logic any_live(input logic [31:0] pend, input logic [31:0] mask);
    return |(pend & ~mask);
  endfunction

  // New pending vector: clear first, then set (set wins)
  function automatic logic [31:0] pend_next(input logic [31:0] cur, input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/ictl_edge.sv
module ictl_edge #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end

  AST_RISE_NEEDS_LOW_PAST: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |-> (($past(lvl_i) & rise_o) == '0)) else $error("rise without low"); // R7

endmodule

// File: rtl/ictl_src_bank.sv
module ictl_src_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_we,
  input  logic         set_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] rise,
  output logic [N-1:0] pend
);

  logic [N-1:0] clr_v, set_v, pend_d;

  assign clr_v  = clr_we ? wbits : '0;
  assign set_v  = (set_we ? wbits : '0) | rise;
  assign pend_d = N'(ictl_pkg::pend_next(32'(pend), 32'(clr_v), 32'(set_v)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise))) else $error("event lost"); // R8

  AST_PEND_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> ($past(set_we) || ($past(rise) != '0))) else $error("pending set without cause"); // R7

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && rise == '0) |=> ((pend & $past(wbits)) == '0)) else $error("clear failed"); // R4

endmodule

// File: rtl/ictl_mask_bank.sv
module ictl_mask_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unmask_we,
  input  logic         mask_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] mask
);

  logic [N-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (unmask_we) mask_d = mask_d & ~wbits;
    if (mask_we)   mask_d = mask_d | wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= mask_d;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(unmask_we || mask_we) |=> $stable(mask)) else $error("mask moved"); // R2

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_we && !mask_we) |=> ((mask & $past(wbits)) == '0)) else $error("unmask failed"); // R3

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> ((mask & $past(wbits)) == $past(wbits))) else $error("mask set failed"); // R3

endmodule

// File: rtl/ictl_cfg_stat.sv
module ictl_cfg_stat #(
  parameter int CW = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic [CW-1:0]          wbits,
  output logic [CW-1:0]          ctl,
  output logic [ictl_pkg::ST_W-1:0] stat
);

  import ictl_pkg::*;

  logic scan_req;
  assign scan_req = ctl_we & wbits[CT_SCAN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      stat <= ST_W'(1) << ST_CMPL;
    end else begin
      if (ctl_we) ctl <= wbits;
      if (scan_req) begin
        stat[ST_DONE] <= 1'b1;
        stat[ST_PASS] <= 1'b1;
      end
    end
  end

  AST_SCAN_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |=> (stat[ST_DONE] && stat[ST_PASS])) else $error("scan not reported"); // R9

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & $past(stat)) == $past(stat))) else $error("status bit dropped"); // R9

endmodule

// File: rtl/ictl_top.sv
module ictl_top #(
  parameter int NSRC   = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CTL_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   evt_i,
  output logic              irq_o
);

  import ictl_pkg::*;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic we_pend, we_unms, we_mset, we_trig, we_ctrl;
  logic [NSRC-1:0]  rise, pend, mask;
  logic [CTL_W-1:0] ctl;
  logic [ST_W-1:0]  stat;
  logic             unused_hi;

  assign we_pend = reg_wr & hit(reg_addr, OFF_PEND);
  assign we_unms = reg_wr & hit(reg_addr, OFF_UNMS);
  assign we_mset = reg_wr & hit(reg_addr, OFF_MSET);
  assign we_trig = reg_wr & hit(reg_addr, OFF_TRIG);
  assign we_ctrl = reg_wr & hit(reg_addr, OFF_CTRL);
  assign unused_hi = ^reg_wdata[DATA_W-1:CTL_W];

  ictl_edge #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_i), .rise_o(rise)
  );

  ictl_src_bank #(.N(NSRC)) u_src (
    .clk(clk), .rst_n(rst_n), .clr_we(we_pend), .set_we(we_trig),
    .wbits(reg_wdata[NSRC-1:0]), .rise(rise), .pend(pend)
  );

  ictl_mask_bank #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .unmask_we(we_unms), .mask_we(we_mset),
    .wbits(reg_wdata[NSRC-1:0]), .mask(mask)
  );

  ictl_cfg_stat #(.CW(CTL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ctl_we(we_ctrl),
    .wbits(reg_wdata[CTL_W-1:0]), .ctl(ctl), .stat(stat)
  );

  assign irq_o = any_live(32'(pend), 32'(mask));

  always_comb begin
    reg_rdata = '0;
    if      (hit(reg_addr, OFF_PEND)) reg_rdata = DATA_W'(pend);
    else if (hit(reg_addr, OFF_MASK)) reg_rdata = DATA_W'(mask);
    else if (hit(reg_addr, OFF_CTRL)) reg_rdata = DATA_W'(ctl);
    else if (hit(reg_addr, OFF_STAT)) reg_rdata = DATA_W'(stat);
  end

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend != '0) && (mask != '1))) else $error("irq without cause"); // R6

  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq_o) else $error("irq while all masked"); // R6

  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !(we_pend || we_unms || we_mset || we_trig || we_ctrl) && rise == '0)
      |=> ($stable(pend) && $stable(mask) && $stable(ctl))) else $error("stray write"); // R10

endmodule

// File: tb/tb_ictl_top.sv
`timescale 1ns/1ps
module tb_ictl_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [9:0]  m_pend, m_mask, m_prev;
  logic [14:0] m_ctl;
  logic [2:0]  m_stat;

  always #10 clk = ~clk;

  ictl_top dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .evt_i(evt), .irq_o(irq)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return {22'd0, m_pend};
      8'h04:   return {22'd0, m_mask};
      8'h18:   return {17'd0, m_ctl};
      8'h20:   return {29'd0, m_stat};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_pend & ~m_mask) != 10'd0;
  endfunction

  task automatic model_edge(input logic w, input logic [7:0] a, input logic [31:0] d,
                            input logic [9:0] e);
    logic [9:0] r;
    r = e & ~m_prev;
    m_prev = e;
    if (w) begin
      case (a)
        8'h00: m_pend = m_pend & ~d[9:0];
        8'h08: m_mask = m_mask & ~d[9:0];
        8'h0C: m_mask = m_mask | d[9:0];
        8'h10: m_pend = m_pend | d[9:0];
        8'h18: begin m_ctl = d[14:0]; if (d[0]) m_stat = m_stat | 3'b110; end
        default: ;
      endcase
    end
    m_pend = m_pend | r;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, addr, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
    for (int i = 0; i < 10; i++) begin
      addr = offs[i];
      #1;
      chk(tag, rdata, exp_read(offs[i]));
    end
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  // Called at a falling edge; applies one rising edge, checks, returns at next falling edge
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [9:0] e, input string tag);
    wr = w; addr = a; wdata = d; evt = e;
    model_edge(w, a, d, e);
    @(posedge clk);
    #2;
    wr = 1'b0;
    check_all(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pick [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h18, 8'h20, 8'h14};
    logic [9:0] ev;
    void'($urandom(32'd4242));
    m_pend = '0; m_mask = 10'h3FF; m_prev = '0; m_ctl = '0; m_stat = 3'b001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    chk("R1 reset values", {22'd0, m_mask}, 32'h3FF);

    // R2: direct mask write ignored
    step(1'b1, 8'h04, 32'h0, 10'h0, "R2");
    // R5: trigger while masked, irq stays low
    step(1'b1, 8'h10, 32'h005, 10'h0, "R5");
    chk("R5 masked no irq", {31'd0, irq}, 32'd0);
    // R3/R6: unmask source 0 raises irq
    step(1'b1, 8'h08, 32'h001, 10'h0, "R3");
    chk("R6 irq up", {31'd0, irq}, 32'd1);
    // R4: clear bit 0 drops irq, bit 2 stays
    step(1'b1, 8'h00, 32'hFFFF_FC01, 10'h0, "R4");
    chk("R4 bit2 kept", {31'd0, irq}, 32'd0);
    // R3: disable then unmask again
    step(1'b1, 8'h0C, 32'h001, 10'h0, "R3");
    step(1'b1, 8'h08, 32'h3F8, 10'h0, "R3");
    // R7: edge sets, level does not re-set after clear
    step(1'b0, 8'h00, 32'h0, 10'h008, "R7");
    chk("R7 edge set", rdata & 32'h8, 32'h0);  // addr after check_all is 0x24 -> reads zero
    step(1'b1, 8'h00, 32'h008, 10'h008, "R7");
    step(1'b0, 8'h00, 32'h0, 10'h008, "R7");
    // R8: event edge on same edge as clear
    step(1'b1, 8'h00, 32'h020, 10'h028, "R8");
    // R9: control and scan request
    step(1'b1, 8'h18, 32'hFFFF_FFFE, 10'h028, "R9");
    step(1'b1, 8'h18, 32'hFFFF_FFFF, 10'h028, "R9");
    step(1'b1, 8'h20, 32'h0, 10'h028, "R9");
    // R10: unmapped writes
    step(1'b1, 8'h14, 32'hFFFF_FFFF, 10'h000, "R10");
    step(1'b1, 8'h1C, 32'hFFFF_FFFF, 10'h000, "R10");

    ev = 10'h000;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      a = pick[$urandom_range(0, 7)];
      if ($urandom_range(0, 3) == 0) ev = ev ^ 10'($urandom);
      step($urandom_range(0, 1) == 1, a, $urandom, ev, "R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule